// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block watches the control pins of a synchronous DRAM command bus and turns each clock's pin pattern into a named command. It keeps a small state machine for every bank, so it knows which banks hold an open row and which row that is. It also counts how many cycles have gone by since each bank was opened, and judges every command against that state. A command that breaks a rule raises one error flag and leaves the tracked state unchanged. A command that is allowed is reported as accepted and takes effect.

Refresh takes its row and bank from an internal counter, never from the bus. The counter steps once for each accepted auto refresh. It also steps once when self refresh is entered. Inside self refresh it steps again every `SREF_PERIOD` cycles. Every refresh form is refused while any bank is open. A controller model, a protocol monitor or a memory model can sit behind this block and rely on its decoded command stream.

The mode machine has two states. In `M_RUN`, commands are decoded and judged. An accepted self-refresh entry (refresh pins with `cke` low) moves it to `M_SELF`. In `M_SELF`, all bus commands are ignored, and a cycle with `cke` high returns it to `M_RUN`. Each bank machine has three states:
- `BK_IDLE` moves to `BK_WAIT` on an accepted activate, or straight to `BK_OPEN` when `TRCD` is 1.
- `BK_WAIT` counts down the row-to-column delay and then moves to `BK_OPEN`.
- `BK_WAIT` and `BK_OPEN` both return to `BK_IDLE` on a precharge.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: Pins `{ras_n,cas_n,we_n}` are decoded on each rising edge and reported one register later on `cmd_code`. The codes are:
  - `011` is activate, code 1.
  - `101` is read, code 2.
  - `100` is write, code 3.
  - `010` is precharge, code 4.
  - `001` is auto refresh (code 5) when `cke` is high, and self-refresh entry (code 6) when `cke` is low.
  - Every other pattern, including all-high, gives code 0 with `cmd_ok` low and no error.
- R2: An activate to an idle bank is accepted. It sets that bank's bit in `bank_open`, and `cmd_row` reports the row given.
- R3: A read or write to a bank activated at edge t is accepted at edge t+`TRCD` or later. Before that it raises `err_trcd`, is not accepted, and leaves the bank opening.
- R4: A read or write to an idle bank raises `err_col_closed` and is not accepted.
- R5: An activate to a bank that is already open or opening raises `err_act_open`. The row held for that bank does not change.
- R6: A precharge is always accepted and makes the addressed bank idle. A precharge to an idle bank raises no error.
- R7: Several banks can be open at once. An accepted read or write reports, on `cmd_row`, the row held by its own bank.
- R8: A refresh or self-refresh entry while any bank is open raises `err_ref_busy`. It is not accepted, does not move the refresh counter and does not enter self refresh.
- R9: An accepted refresh reports the counter value as `cmd_bank`/`cmd_row`. The counter `{ref_bank,ref_row}` then advances by one and wraps to zero after its maximum value.
- R10: After an accepted self-refresh entry (which advances the counter once), `self_ref` is high. Bus commands are ignored, the counter advances once every `SREF_PERIOD` cycles with `cke` low, and the first cycle with `cke` high returns to normal decoding.
- R11: After reset all outputs are zero: no bank open, counter at zero, not in self refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; low with refresh pins selects self refresh, high leaves it |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_addr | input | BA_W | Bank selected by the command |
| row_addr | input | ROW_W | Row given with an activate |
| cmd_code | output | 3 | Decoded command code (R1) |
| cmd_ok | output | 1 | Command accepted and applied |
| err_col_closed | output | 1 | Column command to an idle bank |
| err_act_open | output | 1 | Activate to a bank already open |
| err_trcd | output | 1 | Column command before the row-to-column delay |
| err_ref_busy | output | 1 | Refresh while a bank is open |
| cmd_bank | output | BA_W | Bank of the reported command (refresh: counter bank) |
| cmd_row | output | ROW_W | Row of the reported command |
| bank_open | output | NUM_BANKS | One bit per bank, set while open or opening |
| ref_bank | output | BA_W | Bank the next refresh will use |
| ref_row | output | ROW_W | Row the next refresh will use |
| self_ref | output | 1 | High while in self refresh |

## Verification
The bench builds the block with four banks, a 3-bit row, `TRCD` of 3 and `SREF_PERIOD` of 4. The narrow row shrinks the refresh counter to 32 values, so a full wrap of bank and row fits in a few dozen refresh commands. A delay of 3 leaves room to test both rejected column cycles before acceptance. A self-refresh period of 4 gives two periodic advances inside an eight-cycle stay.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_REF  = 3'd5,
        CMD_SREF = 3'd6
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE = 2'd0,
        BK_WAIT = 2'd1,
        BK_OPEN = 2'd2
    } bank_st_e;

    typedef enum logic {
        M_RUN  = 1'b0,
        M_SELF = 1'b1
    } mode_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdcmd_pkg::*;
(
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic cke,
    output cmd_e pin_cmd
);

    always_comb begin
        unique case ({ras_n, cas_n, we_n})
            3'b011:  pin_cmd = CMD_ACT;
            3'b101:  pin_cmd = CMD_RD;
            3'b100:  pin_cmd = CMD_WR;
            3'b010:  pin_cmd = CMD_PRE;
            3'b001:  pin_cmd = cke ? CMD_REF : CMD_SREF;
            default: pin_cmd = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sdcmd_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int TRCD  = 3,
    localparam int CW   = $clog2(TRCD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_req,
    input  logic             close_req,
    input  logic [ROW_W-1:0] act_row,
    output logic             is_idle,
    output logic             is_ready,
    output logic [ROW_W-1:0] open_row
);

    bank_st_e         state_q, state_d;
    logic [CW-1:0]    cnt_q, cnt_d;
    logic [ROW_W-1:0] row_q, row_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BK_IDLE;
            cnt_q   <= '0;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            row_q   <= row_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        row_d   = row_q;
        unique case (state_q)
            BK_IDLE: begin
                if (open_req) begin
                    row_d = act_row;
                    if (TRCD <= 1) begin
                        state_d = BK_OPEN;
                    end else begin
                        state_d = BK_WAIT;
                        cnt_d   = CW'(TRCD - 1);
                    end
                end
            end
            BK_WAIT: begin
                if (close_req) begin
                    state_d = BK_IDLE;
                end else if (cnt_q <= CW'(1)) begin
                    state_d = BK_OPEN;
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
            BK_OPEN: begin
                if (close_req) state_d = BK_IDLE;
            end
            default: state_d = BK_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        is_idle  = (state_q == BK_IDLE);
        is_ready = (state_q == BK_OPEN);
        open_row = row_q;
    end

endmodule

// File: rtl/sdram_refresh_ctr.sv
module sdram_refresh_ctr #(
    parameter int REF_W       = 14,
    parameter int SREF_PERIOD = 8,
    localparam int TW         = $clog2(SREF_PERIOD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_adv,
    input  logic             self_run,
    output logic [REF_W-1:0] ref_addr
);

    logic [REF_W-1:0] addr_q;
    logic [TW-1:0]    tick_q;
    logic             tick_wrap;
    logic             step;

    always_comb begin
        tick_wrap = self_run && (tick_q == TW'(SREF_PERIOD - 1));
        step      = cmd_adv || tick_wrap;
        ref_addr  = addr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            tick_q <= '0;
        end else begin
            if (step) addr_q <= addr_q + REF_W'(1);
            if (!self_run)     tick_q <= '0;
            else if (tick_wrap) tick_q <= '0;
            else                tick_q <= tick_q + TW'(1);
        end
    end

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
    import sdcmd_pkg::*;
#(
    parameter int NUM_BANKS   = 4,
    parameter int ROW_W       = 12,
    parameter int TRCD        = 3,
    parameter int SREF_PERIOD = 8,
    localparam int BA_W       = $clog2(NUM_BANKS),
    localparam int REF_W      = ROW_W + BA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cke,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BA_W-1:0]      bank_addr,
    input  logic [ROW_W-1:0]     row_addr,
    output logic [2:0]           cmd_code,
    output logic                 cmd_ok,
    output logic                 err_col_closed,
    output logic                 err_act_open,
    output logic                 err_trcd,
    output logic                 err_ref_busy,
    output logic [BA_W-1:0]      cmd_bank,
    output logic [ROW_W-1:0]     cmd_row,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic [BA_W-1:0]      ref_bank,
    output logic [ROW_W-1:0]     ref_row,
    output logic                 self_ref
);

    cmd_e                 pin_cmd;
    mode_e                mode_q, mode_d;
    logic [NUM_BANKS-1:0] bk_idle, bk_ready, do_act, do_pre;
    logic [ROW_W-1:0]     bk_row [NUM_BANKS];
    logic [REF_W-1:0]     ref_addr;
    logic                 ref_adv, all_idle, self_run;

    cmd_e                 code_d;
    logic                 ok_d, e_closed_d, e_open_d, e_trcd_d, e_ref_d;
    logic [BA_W-1:0]      bank_d;
    logic [ROW_W-1:0]     row_d;

    cmd_e                 code_q;
    logic                 ok_q, e_closed_q, e_open_q, e_trcd_q, e_ref_q;
    logic [BA_W-1:0]      bank_q;
    logic [ROW_W-1:0]     row_q;

    sdram_cmd_decode u_dec (
        .ras_n  (ras_n),
        .cas_n  (cas_n),
        .we_n   (we_n),
        .cke    (cke),
        .pin_cmd(pin_cmd)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdram_bank_tracker #(
            .ROW_W(ROW_W),
            .TRCD (TRCD)
        ) u_trk (
            .clk      (clk),
            .rst_n    (rst_n),
            .open_req (do_act[b]),
            .close_req(do_pre[b]),
            .act_row  (row_addr),
            .is_idle  (bk_idle[b]),
            .is_ready (bk_ready[b]),
            .open_row (bk_row[b])
        );
    end

    always_comb begin
        all_idle = &bk_idle;
        self_run = (mode_q == M_SELF) && !cke;
    end

    sdram_refresh_ctr #(
        .REF_W      (REF_W),
        .SREF_PERIOD(SREF_PERIOD)
    ) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_adv (ref_adv),
        .self_run(self_run),
        .ref_addr(ref_addr)
    );

    // mode state register
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= M_RUN;
        else        mode_q <= mode_d;
    end

    // command judgement and mode transitions
    always_comb begin
        mode_d     = mode_q;
        code_d     = CMD_NOP;
        ok_d       = 1'b0;
        e_closed_d = 1'b0;
        e_open_d   = 1'b0;
        e_trcd_d   = 1'b0;
        e_ref_d    = 1'b0;
        bank_d     = '0;
        row_d      = '0;
        do_act     = '0;
        do_pre     = '0;
        ref_adv    = 1'b0;
        unique case (mode_q)
            M_RUN: begin
                unique case (pin_cmd)
                    CMD_ACT: begin
                        code_d = CMD_ACT;
                        bank_d = bank_addr;
                        row_d  = row_addr;
                        if (!bk_idle[bank_addr]) begin
                            e_open_d = 1'b1;
                        end else begin
                            ok_d             = 1'b1;
                            do_act[bank_addr] = 1'b1;
                        end
                    end
                    CMD_RD, CMD_WR: begin
                        code_d = pin_cmd;
                        bank_d = bank_addr;
                        if (bk_idle[bank_addr]) begin
                            e_closed_d = 1'b1;
                        end else if (!bk_ready[bank_addr]) begin
                            e_trcd_d = 1'b1;
                        end else begin
                            ok_d  = 1'b1;
                            row_d = bk_row[bank_addr];
                        end
                    end
                    CMD_PRE: begin
                        code_d            = CMD_PRE;
                        bank_d            = bank_addr;
                        ok_d              = 1'b1;
                        do_pre[bank_addr] = 1'b1;
                    end
                    CMD_REF, CMD_SREF: begin
                        code_d = pin_cmd;
                        bank_d = ref_addr[REF_W-1:ROW_W];
                        row_d  = ref_addr[ROW_W-1:0];
                        if (!all_idle) begin
                            e_ref_d = 1'b1;
                        end else begin
                            ok_d    = 1'b1;
                            ref_adv = 1'b1;
                            if (pin_cmd == CMD_SREF) mode_d = M_SELF;
                        end
                    end
                    default: ;
                endcase
            end
            M_SELF: begin
                if (cke) mode_d = M_RUN;
            end
            default: mode_d = M_RUN;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q     <= CMD_NOP;
            ok_q       <= 1'b0;
            e_closed_q <= 1'b0;
            e_open_q   <= 1'b0;
            e_trcd_q   <= 1'b0;
            e_ref_q    <= 1'b0;
            bank_q     <= '0;
            row_q      <= '0;
        end else begin
            code_q     <= code_d;
            ok_q       <= ok_d;
            e_closed_q <= e_closed_d;
            e_open_q   <= e_open_d;
            e_trcd_q   <= e_trcd_d;
            e_ref_q    <= e_ref_d;
            bank_q     <= bank_d;
            row_q      <= row_d;
        end
    end

    always_comb begin
        cmd_code       = code_q;
        cmd_ok         = ok_q;
        err_col_closed = e_closed_q;
        err_act_open   = e_open_q;
        err_trcd       = e_trcd_q;
        err_ref_busy   = e_ref_q;
        cmd_bank       = bank_q;
        cmd_row        = row_q;
        bank_open      = ~bk_idle;
        ref_bank       = ref_addr[REF_W-1:ROW_W];
        ref_row        = ref_addr[ROW_W-1:0];
        self_ref       = (mode_q == M_SELF);
    end

endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    localparam int BA_W     = $clog2(NUM_BANKS),
    localparam int REF_W    = ROW_W + BA_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2:0]           cmd_code,
    input logic                 cmd_ok,
    input logic                 err_col_closed,
    input logic                 err_act_open,
    input logic                 err_trcd,
    input logic                 err_ref_busy,
    input logic [BA_W-1:0]      cmd_bank,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic [BA_W-1:0]      ref_bank,
    input logic [ROW_W-1:0]     ref_row,
    input logic                 self_ref
);

    logic [REF_W-1:0] ref_now;
    assign ref_now = {ref_bank, ref_row};

    // R1: at most one judgement per reported command
    a_r1_single_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_ok, err_col_closed, err_act_open, err_trcd, err_ref_busy}));

    // R2: accepted activate leaves its bank open
    a_r2_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok && cmd_code == 3'd1) |-> bank_open[cmd_bank]);

    // R4: rejected column command leaves its bank closed
    a_r4_closed_stays: assert property (@(posedge clk) disable iff (!rst_n)
        err_col_closed |-> !bank_open[cmd_bank]);

    // R6: accepted precharge leaves its bank closed
    a_r6_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok && cmd_code == 3'd4) |-> !bank_open[cmd_bank]);

    // R8: accepted refresh forms only with every bank idle beforehand
    a_r8_ref_all_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok && (cmd_code == 3'd5 || cmd_code == 3'd6)) |-> ($past(bank_open) == '0));

    // R8: rejected refresh does not move the counter
    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        err_ref_busy |-> (ref_now == $past(ref_now)));

    // R9: accepted refresh steps the counter by one
    a_r9_ref_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok && cmd_code == 3'd5) |-> (ref_now == $past(ref_now) + REF_W'(1)));

    // R10: nothing is accepted and no bank moves while in self refresh
    a_r10_self_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (self_ref && $past(self_ref)) |-> (!cmd_ok && bank_open == $past(bank_open)));

endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(
    .NUM_BANKS(NUM_BANKS),
    .ROW_W    (ROW_W)
) u_chk (.*);

// File: tb/tb_sdram_cmd_tracker.sv
module tb_sdram_cmd_tracker;

    localparam int NB = 4;
    localparam int RW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke = 1'b1;
    logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]    bank_addr = '0;
    logic [RW-1:0] row_addr = '0;
    logic [2:0]    cmd_code;
    logic          cmd_ok, err_col_closed, err_act_open, err_trcd, err_ref_busy;
    logic [1:0]    cmd_bank;
    logic [RW-1:0] cmd_row;
    logic [NB-1:0] bank_open;
    logic [1:0]    ref_bank;
    logic [RW-1:0] ref_row;
    logic          self_ref;

    int tests = 0;
    int fails = 0;
    int exp_ref = 0;

    always #4 clk = ~clk;

    sdram_cmd_tracker #(
        .NUM_BANKS(NB), .ROW_W(RW), .TRCD(3), .SREF_PERIOD(4)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .bank_addr(bank_addr), .row_addr(row_addr),
        .cmd_code(cmd_code), .cmd_ok(cmd_ok), .err_col_closed(err_col_closed),
        .err_act_open(err_act_open), .err_trcd(err_trcd), .err_ref_busy(err_ref_busy),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .bank_open(bank_open),
        .ref_bank(ref_bank), .ref_row(ref_row), .self_ref(self_ref)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive at a falling edge, return at the next falling edge
    task automatic issue(input logic r, input logic c, input logic w,
                         input int ba, input int row, input logic k);
        ras_n = r; cas_n = c; we_n = w; cke = k;
        bank_addr = 2'(ba); row_addr = RW'(row);
        @(negedge clk);
    endtask

    task automatic nop();             issue(1, 1, 1, 0, 0, 1);   endtask
    task automatic act(int ba, int r); issue(0, 1, 1, ba, r, 1);  endtask
    task automatic rd(int ba);         issue(1, 0, 1, ba, 0, 1);  endtask
    task automatic wr(int ba);         issue(1, 0, 0, ba, 0, 1);  endtask
    task automatic pre(int ba);        issue(0, 1, 0, ba, 0, 1);  endtask
    task automatic refc();             issue(0, 0, 1, 0, 0, 1);   endtask

    task automatic chk_ref(input string req);
        chk(req, {ref_bank, ref_row}, exp_ref);
    endtask

    task automatic t_reset();
        chk("R11 code", cmd_code, 0);
        chk("R11 ok", cmd_ok, 0);
        chk("R11 open", bank_open, 0);
        chk("R11 ref", {ref_bank, ref_row}, 0);
        chk("R11 self", self_ref, 0);
    endtask

    task automatic t_decode();
        nop();
        chk("R1 nop code", cmd_code, 0);  chk("R1 nop ok", cmd_ok, 0);
        issue(1, 1, 0, 0, 0, 1);
        chk("R1 110 code", cmd_code, 0);  chk("R1 110 ok", cmd_ok, 0);
        issue(0, 0, 0, 0, 0, 1);
        chk("R1 000 code", cmd_code, 0);  chk("R1 000 err", err_ref_busy, 0);
        pre(2);
        chk("R6 idle pre code", cmd_code, 4); chk("R6 idle pre ok", cmd_ok, 1);
        chk("R6 idle pre open", bank_open, 0);
    endtask

    task automatic t_trcd();
        act(0, 5);
        chk("R2 act code", cmd_code, 1); chk("R2 act ok", cmd_ok, 1);
        chk("R2 act row", cmd_row, 5);   chk("R2 open", bank_open, 4'b0001);
        rd(0);
        chk("R3 early rd err", err_trcd, 1); chk("R3 early rd ok", cmd_ok, 0);
        chk("R3 early rd code", cmd_code, 2);
        wr(0);
        chk("R3 early wr err", err_trcd, 1); chk("R3 early wr code", cmd_code, 3);
        rd(0);
        chk("R3 rd at trcd ok", cmd_ok, 1); chk("R3 rd row", cmd_row, 5);
        chk("R3 rd err", err_trcd, 0);
        pre(0);
        chk("R6 pre closes", bank_open, 0);
    endtask

    task automatic t_closed();
        rd(1);
        chk("R4 rd closed err", err_col_closed, 1); chk("R4 rd closed ok", cmd_ok, 0);
        wr(3);
        chk("R4 wr closed err", err_col_closed, 1); chk("R4 wr closed code", cmd_code, 3);
    endtask

    task automatic t_reopen();
        act(2, 6);
        act(2, 1);
        chk("R5 reopen err", err_act_open, 1); chk("R5 reopen ok", cmd_ok, 0);
        nop(); nop();
        rd(2);
        chk("R5 row kept", cmd_row, 6); chk("R5 rd ok", cmd_ok, 1);
        pre(2);
        chk("R6 pre 2", bank_open, 0);
    endtask

    task automatic t_multi();
        act(0, 3); act(1, 4); act(3, 7);
        chk("R7 three open", bank_open, 4'b1011);
        nop(); nop();
        rd(0); chk("R7 rd b0 row", cmd_row, 3); chk("R7 rd b0 ok", cmd_ok, 1);
        wr(1); chk("R7 wr b1 row", cmd_row, 4); chk("R7 wr b1 ok", cmd_ok, 1);
        rd(3); chk("R7 rd b3 row", cmd_row, 7); chk("R7 rd b3 bank", cmd_bank, 3);
        rd(0); chk("R7 rd b0 again", cmd_row, 3);
        pre(1); chk("R6 pre b1", bank_open, 4'b1001);
        rd(1); chk("R4 rd after pre", err_col_closed, 1);
    endtask

    task automatic t_ref_busy();
        refc();
        chk("R8 busy err", err_ref_busy, 1); chk("R8 busy ok", cmd_ok, 0);
        chk_ref("R8 counter held");
        issue(0, 0, 1, 0, 0, 0);
        chk("R8 sref busy err", err_ref_busy, 1); chk("R8 sref busy self", self_ref, 0);
        chk_ref("R8 sref counter held");
        pre(0); pre(3);
        refc();
        chk("R9 ref ok", cmd_ok, 1); chk("R9 ref code", cmd_code, 5);
        chk("R9 ref bank used", cmd_bank, exp_ref >> RW);
        chk("R9 ref row used", cmd_row, exp_ref & 7);
        exp_ref = (exp_ref + 1) % 32;
        chk_ref("R9 counter step");
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 32; i++) begin
            refc();
            chk("R9 ref used", {cmd_bank, cmd_row}, exp_ref);
            exp_ref = (exp_ref + 1) % 32;
            chk_ref("R9 counter");
            if (exp_ref == 0) chk("R9 wrap to zero", {ref_bank, ref_row}, 0);
        end
    endtask

    task automatic t_self();
        int start;
        start = exp_ref;
        issue(0, 0, 1, 0, 0, 0);
        chk("R10 entry code", cmd_code, 6); chk("R10 entry ok", cmd_ok, 1);
        chk("R10 self on", self_ref, 1);
        exp_ref = (start + 1) % 32;
        chk_ref("R10 entry step");
        issue(0, 1, 1, 0, 2, 0);
        chk("R10 act ignored open", bank_open, 0); chk("R10 act ignored ok", cmd_ok, 0);
        for (int i = 0; i < 7; i++) issue(1, 1, 1, 0, 0, 0);
        chk("R10 still self", self_ref, 1);
        issue(1, 1, 1, 0, 0, 1);
        chk("R10 exit", self_ref, 0);
        exp_ref = (start + 3) % 32;
        chk_ref("R10 periodic steps");
        act(0, 2);
        chk("R10 act after exit", cmd_ok, 1); chk("R10 open after exit", bank_open, 4'b0001);
        pre(0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_decode();
        t_trcd();
        t_closed();
        t_reopen();
        t_multi();
        t_ref_busy();
        t_wrap();
        t_self();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule